// File: doc/BRIEF.md
# Twisted-Ring Low-Activity Test Pattern Source

This block generates stimulus patterns for on-chip self-test while keeping switching activity low. Its core is an N-bit shift register closed into a ring through an inverter: on each advancing clock, the register shifts one place towards its most significant end, and the complement of the old top bit enters at the bottom. Starting from all zeros, ones fill the register from the least significant end until it is all ones. Zeros then fill it the same way. The ring returns to all zeros after 2N steps, and exactly one register bit changes on every step.

The raw ring state is too regular to use directly as test stimulus. A fixed combinational network therefore derives a second pattern from it: the bits are reordered by a stride permutation, and each output bit is the XOR of two neighbouring permuted bits. This network holds no state, so the register keeps its single-bit-change behaviour.

A one-cycle pulse marks each return to all zeros through normal advancing. A seed strobe loads any N-bit value into the ring. If a load or a disturbance leaves the ring in a state that is not a valid twisted-ring code, the ring is forced to all zeros on the next clock. This keeps it out of parasitic loops.

Top module: `johnson_tpg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next ring state is all zeros and `wrap_o` is 0. Reset takes priority over every other input.
- R2: With `run_i` high, `load_i` low and a legal ring state, the next ring state is `{ring_o[N-2:0], ~ring_o[N-1]}`. From zero with N=5, the sequence is 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000, and then it returns to 00000.
- R3: Every advance from a legal state changes exactly one bit of `ring_o`, and the ring period is 2N advances.
- R4: `wrap_o` is high for exactly one cycle, in the cycle after an advance that moves the ring from `{1, 0...0}` to all zeros. It stays low after a load, a correction or a hold, even when any of these leaves the ring at zero.
- R5: With `run_i` and `load_i` both low and a legal state, the ring holds its value.
- R6: When `load_i` is high, the next ring state equals `seed_i`, whatever the value of `run_i`. A load overrides both the advance and the illegal-state correction.
- R7: A state is legal when at most one pair of adjacent bits differs. With `load_i` low, an illegal state becomes all zeros on the next clock, whatever the value of `run_i`.
- R8: In the same cycle as the ring state, `pattern_o[i]` equals `ring_o[(i*S)%N] ^ ring_o[((i+1)*S)%N]`. Here S is the `STRIDE` parameter (default 2, which must be coprime with N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Advance enable |
| load_i | input | 1 | Seed load strobe |
| seed_i | input | N | Value loaded into the ring |
| ring_o | output | N | Raw ring state |
| pattern_o | output | N | Scrambled pattern |
| wrap_o | output | 1 | One-cycle pulse on return to zero |

## Verification
The key collisions are a seed load arriving in the same cycle as the advance that would wrap the ring to zero, and a correction arriving in the same cycle as an advance request. The bench walks the ring to `10000` and then strobes a load with `run_i` high. It expects the seed in the ring and no wrap pulse. Because that seed is illegal, the following cycle with `run_i` high must produce zeros, not a shifted value, and again no pulse. A reset applied together with a load and `run_i` checks the top of the priority order.

// File: rtl/jtpg_pkg.sv
package jtpg_pkg;

    // Action applied to the ring register on the next clock edge
    typedef enum logic [2:0] {
        STEP_HOLD  = 3'd0,
        STEP_SHIFT = 3'd1,
        STEP_LOAD  = 3'd2,
        STEP_FIX   = 3'd3,
        STEP_CLEAR = 3'd4
    } jt_step_e;

    // Decoded control inputs presented to the step selector
    typedef struct packed {
        logic clear;
        logic load;
        logic legal;
        logic run;
    } jt_ctrl_t;

    // Source index for output position i of the stride permutation
    function automatic int perm_idx(input int i, input int stride, input int n);
        return (i * stride) % n;
    endfunction

endpackage

// File: rtl/jtpg_legal.sv
module jtpg_legal #(
    parameter int N = 5
) (
    input  logic [N-1:0] state_i,
    output logic         legal_o
);
    localparam int EDGES = N - 1;

    logic [EDGES-1:0] edge_diff;

    genvar g;
    generate
        for (g = 0; g < EDGES; g++) begin : g_edge
            assign edge_diff[g] = state_i[g] ^ state_i[g+1];
        end
    endgenerate

    always_comb begin
        legal_o = ($countones(edge_diff) <= 1);
    end
endmodule

// File: rtl/jtpg_ctrl.sv
module jtpg_ctrl
    import jtpg_pkg::*;
(
    input  jt_ctrl_t ctrl_i,
    output jt_step_e step_o
);
    always_comb begin
        if (ctrl_i.clear) begin
            step_o = STEP_CLEAR;
        end else if (ctrl_i.load) begin
            step_o = STEP_LOAD;
        end else if (!ctrl_i.legal) begin
            step_o = STEP_FIX;
        end else if (ctrl_i.run) begin
            step_o = STEP_SHIFT;
        end else begin
            step_o = STEP_HOLD;
        end
    end
endmodule

// File: rtl/jtpg_ring.sv
module jtpg_ring
    import jtpg_pkg::*;
#(
    parameter int N = 5
) (
    input  logic         clk,
    input  jt_step_e     step_i,
    input  logic [N-1:0] seed_i,
    output logic [N-1:0] state_o,
    output logic         wrap_o
);
    localparam logic [N-1:0] LAST_CODE = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] state_q;
    logic         wrap_q;
    logic [N-1:0] shifted;

    always_comb begin
        shifted = {state_q[N-2:0], ~state_q[N-1]};
    end

    always_ff @(posedge clk) begin
        unique case (step_i)
            STEP_CLEAR, STEP_FIX: begin
                state_q <= '0;
                wrap_q  <= 1'b0;
            end
            STEP_LOAD: begin
                state_q <= seed_i;
                wrap_q  <= 1'b0;
            end
            STEP_SHIFT: begin
                state_q <= shifted;
                wrap_q  <= (state_q == LAST_CODE);
            end
            default: begin
                state_q <= state_q;
                wrap_q  <= 1'b0;
            end
        endcase
    end

    assign state_o = state_q;
    assign wrap_o  = wrap_q;
endmodule

// File: rtl/jtpg_scramble.sv
module jtpg_scramble #(
    parameter int N      = 5,
    parameter int STRIDE = 2
) (
    input  logic [N-1:0] ring_i,
    output logic [N-1:0] pattern_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            localparam int SRC_A = jtpg_pkg::perm_idx(g, STRIDE, N);
            localparam int SRC_B = jtpg_pkg::perm_idx(g + 1, STRIDE, N);
            assign pattern_o[g] = ring_i[SRC_A] ^ ring_i[SRC_B];
        end
    endgenerate
endmodule

// File: rtl/johnson_tpg.sv
module johnson_tpg
    import jtpg_pkg::*;
#(
    parameter int N      = 5,
    parameter int STRIDE = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         load_i,
    input  logic [N-1:0] seed_i,
    output logic [N-1:0] ring_o,
    output logic [N-1:0] pattern_o,
    output logic         wrap_o
);
    logic [N-1:0] ring_state;
    logic         state_legal;
    jt_ctrl_t     ctrl;
    jt_step_e     step;

    jtpg_legal #(.N(N)) u_legal (
        .state_i (ring_state),
        .legal_o (state_legal)
    );

    always_comb begin
        ctrl.clear = rst;
        ctrl.load  = load_i;
        ctrl.legal = state_legal;
        ctrl.run   = run_i;
    end

    jtpg_ctrl u_ctrl (
        .ctrl_i (ctrl),
        .step_o (step)
    );

    jtpg_ring #(.N(N)) u_ring (
        .clk     (clk),
        .step_i  (step),
        .seed_i  (seed_i),
        .state_o (ring_state),
        .wrap_o  (wrap_o)
    );

    jtpg_scramble #(.N(N), .STRIDE(STRIDE)) u_scr (
        .ring_i    (ring_state),
        .pattern_o (pattern_o)
    );

    assign ring_o = ring_state;
endmodule

// File: rtl/johnson_tpg_chk.sv
module johnson_tpg_chk #(
    parameter int N = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         run_i,
    input logic         load_i,
    input logic [N-1:0] seed_i,
    input logic [N-1:0] ring_o,
    input logic         wrap_o
);
    localparam logic [N-1:0] TOP_ONLY = {1'b1, {(N-1){1'b0}}};

    logic seen_legal;

    always_comb begin
        int flips;
        flips = 0;
        for (int k = 0; k + 1 < N; k++) begin
            if (ring_o[k] != ring_o[k+1]) flips++;
        end
        seen_legal = (flips < 2);
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ring_o == '0 && !wrap_o));

    // R2
    advance_shift_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run_i) && !$past(load_i) && !$past(rst) && $past(seen_legal))
        |-> ring_o == {$past(ring_o[N-2:0]), ~$past(ring_o[N-1])});

    // R3
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run_i) && !$past(load_i) && !$past(rst) && $past(seen_legal))
        |-> $countones(ring_o ^ $past(ring_o)) == 1);

    // R4
    wrap_origin_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (ring_o == '0 && $past(ring_o) == TOP_ONLY
                    && $past(run_i) && !$past(load_i)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(run_i) && !$past(load_i) && !$past(rst) && $past(seen_legal))
        |-> $stable(ring_o));

    // R6
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(load_i) && !$past(rst)) |-> ring_o == $past(seed_i));

    // R7
    illegal_fix_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_i) && !$past(rst) && !$past(seen_legal)) |-> (ring_o == '0 && !wrap_o));
endmodule

bind johnson_tpg johnson_tpg_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run_i),
    .load_i (load_i),
    .seed_i (seed_i),
    .ring_o (ring_o),
    .wrap_o (wrap_o)
);

// File: tb/johnson_tpg_tb.sv
module johnson_tpg_tb;
    localparam int N = 5;
    localparam int S = 2;

    typedef struct {
        logic [N-1:0] ring;
        logic [N-1:0] pat;
        logic         wrap;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_i = 1'b0;
    logic         load_i = 1'b0;
    logic [N-1:0] seed_i = '0;
    logic [N-1:0] ring_o;
    logic [N-1:0] pattern_o;
    logic         wrap_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];
    logic [N-1:0] m_ring = '0;

    always #2.5 clk = ~clk;

    johnson_tpg #(.N(N), .STRIDE(S)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run_i),
        .load_i    (load_i),
        .seed_i    (seed_i),
        .ring_o    (ring_o),
        .pattern_o (pattern_o),
        .wrap_o    (wrap_o)
    );

    function automatic bit m_legal(input logic [N-1:0] v);
        int d = 0;
        for (int k = 0; k < N - 1; k++) if (v[k] != v[k+1]) d++;
        return d <= 1;
    endfunction

    function automatic logic [N-1:0] m_scr(input logic [N-1:0] v);
        logic [N-1:0] r;
        for (int k = 0; k < N; k++) r[k] = v[(k*S)%N] ^ v[((k+1)*S)%N];
        return r;
    endfunction

    task automatic drive(input logic r, input logic rn, input logic ld,
                         input logic [N-1:0] sd, input string tag);
        exp_t e;
        logic nw;
        @(negedge clk);
        rst = r; run_i = rn; load_i = ld; seed_i = sd;
        nw = 1'b0;
        if (r) m_ring = '0;
        else if (ld) m_ring = sd;
        else if (!m_legal(m_ring)) m_ring = '0;
        else if (rn) begin
            nw = (m_ring == {1'b1, {(N-1){1'b0}}});
            m_ring = {m_ring[N-2:0], ~m_ring[N-1]};
        end
        e.ring = m_ring; e.pat = m_scr(m_ring); e.wrap = nw; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: one expected item per clock edge after the driver starts
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(ring_o === e.ring, {e.tag, " ring"}, int'(ring_o), int'(e.ring));
                check(pattern_o === e.pat, "R8 pattern", int'(pattern_o), int'(e.pat));
                check(wrap_o === e.wrap, "R4 wrap", int'(wrap_o), int'(e.wrap));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        drive(1, 0, 0, '0, "R1");
        drive(1, 1, 1, 5'b10101, "R1");
        for (int i = 0; i < 12; i++) drive(0, 1, 0, '0, "R2 R3");
        for (int i = 0; i < 3; i++) drive(0, 0, 0, '0, "R5");
        drive(0, 1, 1, 5'b00111, "R6");
        for (int i = 0; i < 6; i++) drive(0, 1, 0, '0, "R2");
        // ring now 10000: load collides with the wrapping advance
        drive(0, 1, 1, 5'b01100, "R6");
        drive(0, 1, 0, '0, "R7");
        drive(0, 0, 1, 5'b10101, "R6");
        drive(0, 0, 0, '0, "R7");
        drive(0, 0, 1, 5'b10000, "R6");
        drive(0, 1, 0, '0, "R4");
        drive(0, 0, 0, '0, "R4");
        for (int i = 0; i < 3; i++) drive(0, 1, 0, '0, "R3");
        drive(1, 1, 1, 5'b11111, "R1");
        for (int i = 0; i < 22; i++) drive(0, 1, 0, '0, "R3");
        drive(0, 0, 0, '0, "R5");
        @(posedge clk);
        #2;
        finish_run();
    end
endmodule